// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block takes one byte-granular cache maintenance request (a first byte address, an exclusive end address and an operation: invalidate, clean or flush) and breaks it into a sequence of line-aligned commands for a downstream range walker. Each range command carries an inclusive first-line and last-line address. No range command covers more than 1024 bytes, and none crosses a 4096-byte page. An invalidate can only partly cover the line at either end of its range. Because that line also holds bytes outside the range, it gets a single-line clean-plus-invalidate command instead of a plain invalidate.

Only one command is outstanding at a time. The next command is presented only after the walker has accepted the current one. A write-through override, sampled together with the request, drops all clean work because the cache is then never dirty. After the walker has accepted the last command, the block raises a one-cycle completion pulse. This pulse acts as the barrier for the requester and also appears when the request produced no commands at all. A new request is accepted only after that pulse.

Top module: `cmr_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` then stays low until the cycle after `done`. While `cmd_valid` is high and `cmd_ready` is low, `cmd_kind`, `cmd_first` and `cmd_last` hold their values.
- R3: Range commands (`cmd_kind` 0 = clean range, 1 = invalidate range) have a 32-byte-aligned `cmd_first`. Their `cmd_last` equals the chunk end minus 32, where the chunk end is the smallest of the working end, `cmd_first`+1024 and the next 4096-byte page boundary above `cmd_first`. Chunks follow one another in ascending address order.
- R4: For an invalidate (`req_op` 0) whose start address is not line aligned, the first command is `cmd_kind` 2 (single-line clean-plus-invalidate) with `cmd_first` = `cmd_last` = the start rounded down to 32 bytes. The working start then moves up to the next line boundary.
- R5: For an invalidate whose end is not line aligned, if the working start is still below the end, a `cmd_kind` 2 command on the line holding the end follows, and the working end is rounded down to 32 bytes. Both edge commands come before any range command.
- R6: For clean (`req_op` 1) and flush (`req_op` 2), the start is rounded down and the end rounded up to 32-byte boundaries before splitting.
- R7: A flush without override issues, for each chunk, a clean range command followed at once by an invalidate range command with the same `cmd_first` and `cmd_last`.
- R8: With `wt_override` high at acceptance, a clean issues no commands and a flush issues only its invalidate range commands.
- R9: `done` is high for exactly one cycle. That cycle is the one after the walker accepts the last command, or the one after acceptance if the request produced no commands. `cmd_valid` is low while `done` is high.
- R10: `req_op` 3 is reserved and a request with it issues no commands. A request whose working start is not below its working end issues no range commands. Both cases still complete with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Splitter idle and able to take a request |
| req_base | input | ADDR_W | First byte address of the request |
| req_limit | input | ADDR_W | Exclusive end byte address |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 reserved |
| wt_override | input | 1 | Write-through override, sampled with the request |
| cmd_valid | output | 1 | Command presented to the walker |
| cmd_ready | input | 1 | Walker accepts the command |
| cmd_kind | output | 2 | 0 clean range, 1 invalidate range, 2 single-line clean-plus-invalidate |
| cmd_first | output | ADDR_W | Inclusive first line address |
| cmd_last | output | ADDR_W | Inclusive last line address |
| done | output | 1 | One-cycle completion / barrier pulse |

## Verification
Two of the block's limits can act on the same chunk. The 1024-byte size cap and the page-boundary cap give the same chunk end when a clean starts 3072 bytes into a page. A directed case forces exactly that, and the bench's reference model expects one chunk ending on the page boundary. Two other functions can also act together. In an invalidate, the low-edge advance can leave the working start at or above the end, which must suppress the high-edge command. Requests that begin and end inside one line provoke this and are judged against the model's command list. The random mix runs both situations repeatedly, and the walker's ready line stalls at random to test that commands are held.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_CLEAN_RNG = 2'd0,
        K_INV_RNG   = 2'd1,
        K_LINE_CI   = 2'd2,
        K_NONE      = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_EDGE_LO = 3'd1,
        S_EDGE_HI = 3'd2,
        S_CLEAN   = 3'd3,
        S_INV     = 3'd4,
        S_DONE    = 3'd5
    } st_e;

endpackage

// File: rtl/cmr_req_align.sv
module cmr_req_align
    import cmr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  op_e               op_i,
    input  logic              wt_i,
    output logic [ADDR_W:0]   cur_o,
    output logic [ADDR_W:0]   lim_o,
    output logic              lo_edge_o,
    output logic              hi_edge_o,
    output logic [ADDR_W-1:0] lo_line_o,
    output logic [ADDR_W-1:0] hi_line_o,
    output logic              do_clean_o,
    output logic              do_inv_o
);
    localparam int W1     = ADDR_W + 1;
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam logic [W1-1:0] LINE_STEP = W1'(LINE_BYTES);

    logic [ADDR_W-1:0] base_floor;
    logic [ADDR_W-1:0] limit_floor;
    logic              base_unal;
    logic              limit_unal;
    logic [W1-1:0]     base_up;
    logic [W1-1:0]     limit_up;
    logic [W1-1:0]     inv_cur;

    always_comb begin
        base_floor  = {base_i[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
        limit_floor = {limit_i[ADDR_W-1:LINE_W], {LINE_W{1'b0}}};
        base_unal   = |base_i[LINE_W-1:0];
        limit_unal  = |limit_i[LINE_W-1:0];
        base_up     = {1'b0, base_floor} + LINE_STEP;
        limit_up    = limit_unal ? ({1'b0, limit_floor} + LINE_STEP) : {1'b0, limit_i};
        inv_cur     = base_unal ? base_up : {1'b0, base_i};

        lo_line_o  = base_floor;
        hi_line_o  = limit_floor;
        do_clean_o = ((op_i == OP_CLEAN) || (op_i == OP_FLUSH)) && !wt_i;
        do_inv_o   = (op_i == OP_INV) || (op_i == OP_FLUSH);

        if (op_i == OP_INV) begin
            lo_edge_o = base_unal;
            hi_edge_o = limit_unal && (inv_cur < {1'b0, limit_i});
            cur_o     = inv_cur;
            lim_o     = hi_edge_o ? {1'b0, limit_floor} : {1'b0, limit_i};
        end else begin
            lo_edge_o = 1'b0;
            hi_edge_o = 1'b0;
            cur_o     = {1'b0, base_floor};
            lim_o     = limit_up;
        end
    end
endmodule

// File: rtl/cmr_chunk_calc.sv
module cmr_chunk_calc #(
    parameter int ADDR_W          = 32,
    parameter int PAGE_BYTES      = 4096,
    parameter int MAX_CHUNK_BYTES = 1024
) (
    input  logic [ADDR_W:0] cur_i,
    input  logic [ADDR_W:0] lim_i,
    output logic [ADDR_W:0] chunk_end_o
);
    localparam int W1 = ADDR_W + 1;
    localparam logic [W1-1:0] PAGE_MASK = W1'(PAGE_BYTES - 1);
    localparam logic [W1-1:0] CAP_STEP  = W1'(MAX_CHUNK_BYTES);

    logic [W1-1:0] page_end;
    logic [W1-1:0] cap_end;
    logic [W1-1:0] near_end;

    always_comb begin
        page_end = (cur_i | PAGE_MASK) + W1'(1);
        near_end = (lim_i < page_end) ? lim_i : page_end;
    end

    generate
        if (MAX_CHUNK_BYTES >= PAGE_BYTES) begin : g_page_only
            always_comb begin
                cap_end     = '0;
                chunk_end_o = near_end;
            end
        end else begin : g_size_cap
            always_comb begin
                cap_end     = cur_i + CAP_STEP;
                chunk_end_o = (cap_end < near_end) ? cap_end : near_end;
            end
        end
    endgenerate
endmodule

// File: rtl/cmr_splitter.sv
module cmr_splitter
    import cmr_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LINE_BYTES      = 32,
    parameter int PAGE_BYTES      = 4096,
    parameter int MAX_CHUNK_BYTES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_limit,
    input  logic [1:0]        req_op,
    input  logic              wt_override,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_first,
    output logic [ADDR_W-1:0] cmd_last,
    output logic              done
);
    localparam int W1 = ADDR_W + 1;
    localparam logic [W1-1:0] LINE_STEP = W1'(LINE_BYTES);

    typedef struct packed {
        st_e               st;
        logic [W1-1:0]     cur;
        logic [W1-1:0]     lim;
        logic [ADDR_W-1:0] lo_line;
        logic [ADDR_W-1:0] hi_line;
        logic              hi_edge;
        logic              do_clean;
        logic              do_inv;
    } regs_t;

    regs_t q, d;

    logic [W1-1:0]     a_cur, a_lim;
    logic              a_lo_edge, a_hi_edge, a_clean, a_inv;
    logic [ADDR_W-1:0] a_lo_line, a_hi_line;
    logic [W1-1:0]     chunk_end;
    logic [W1-1:0]     chunk_last;

    cmr_req_align #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .base_i     (req_base),
        .limit_i    (req_limit),
        .op_i       (op_e'(req_op)),
        .wt_i       (wt_override),
        .cur_o      (a_cur),
        .lim_o      (a_lim),
        .lo_edge_o  (a_lo_edge),
        .hi_edge_o  (a_hi_edge),
        .lo_line_o  (a_lo_line),
        .hi_line_o  (a_hi_line),
        .do_clean_o (a_clean),
        .do_inv_o   (a_inv)
    );

    cmr_chunk_calc #(
        .ADDR_W          (ADDR_W),
        .PAGE_BYTES      (PAGE_BYTES),
        .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES)
    ) u_chunk (
        .cur_i       (q.cur),
        .lim_i       (q.lim),
        .chunk_end_o (chunk_end)
    );

    function automatic st_e range_entry(input logic [W1-1:0] cur,
                                        input logic [W1-1:0] lim,
                                        input logic          cln,
                                        input logic          inv);
        if (cur < lim && cln)      return S_CLEAN;
        else if (cur < lim && inv) return S_INV;
        else                       return S_DONE;
    endfunction

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.cur      = a_cur;
                    d.lim      = a_lim;
                    d.lo_line  = a_lo_line;
                    d.hi_line  = a_hi_line;
                    d.hi_edge  = a_hi_edge;
                    d.do_clean = a_clean;
                    d.do_inv   = a_inv;
                    if (a_lo_edge)      d.st = S_EDGE_LO;
                    else if (a_hi_edge) d.st = S_EDGE_HI;
                    else                d.st = range_entry(a_cur, a_lim, a_clean, a_inv);
                end
            end
            S_EDGE_LO: begin
                if (cmd_ready) begin
                    if (q.hi_edge) d.st = S_EDGE_HI;
                    else           d.st = range_entry(q.cur, q.lim, q.do_clean, q.do_inv);
                end
            end
            S_EDGE_HI: begin
                if (cmd_ready) d.st = range_entry(q.cur, q.lim, q.do_clean, q.do_inv);
            end
            S_CLEAN: begin
                if (cmd_ready) begin
                    if (q.do_inv) begin
                        d.st = S_INV;
                    end else begin
                        d.cur = chunk_end;
                        d.st  = range_entry(chunk_end, q.lim, q.do_clean, q.do_inv);
                    end
                end
            end
            S_INV: begin
                if (cmd_ready) begin
                    d.cur = chunk_end;
                    d.st  = range_entry(chunk_end, q.lim, q.do_clean, q.do_inv);
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        chunk_last = chunk_end - LINE_STEP;
        req_ready  = (q.st == S_IDLE);
        done       = (q.st == S_DONE);
        cmd_valid  = 1'b0;
        cmd_kind   = K_NONE;
        cmd_first  = q.cur[ADDR_W-1:0];
        cmd_last   = chunk_last[ADDR_W-1:0];
        unique case (q.st)
            S_EDGE_LO: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_LINE_CI;
                cmd_first = q.lo_line;
                cmd_last  = q.lo_line;
            end
            S_EDGE_HI: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_LINE_CI;
                cmd_first = q.hi_line;
                cmd_last  = q.hi_line;
            end
            S_CLEAN: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_CLEAN_RNG;
            end
            S_INV: begin
                cmd_valid = 1'b1;
                cmd_kind  = K_INV_RNG;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cmr_splitter_chk.sv
module cmr_splitter_chk
    import cmr_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int LINE_BYTES      = 32,
    parameter int PAGE_BYTES      = 4096,
    parameter int MAX_CHUNK_BYTES = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              wt_override,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_first,
    input logic [ADDR_W-1:0] cmd_last,
    input logic              done
);
    localparam int LINE_W = $clog2(LINE_BYTES);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    logic [1:0] op_q;
    logic       wt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= 2'd0;
            wt_q <= 1'b0;
        end else if (req_valid && req_ready) begin
            op_q <= req_op;
            wt_q <= wt_override;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) &&
                                    $stable(cmd_first) && $stable(cmd_last));

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_first[LINE_W-1:0] == '0) && (cmd_last[LINE_W-1:0] == '0));

    p_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_last >= cmd_first) &&
                      ((cmd_last - cmd_first) < ADDR_W'(MAX_CHUNK_BYTES)));

    p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_first[ADDR_W-1:PAGE_W] == cmd_last[ADDR_W-1:PAGE_W]);

    p_edge_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == K_LINE_CI |-> (cmd_first == cmd_last) && (op_q == OP_INV));

    p_flush_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_kind == K_CLEAN_RNG && op_q == OP_FLUSH
        |=> cmd_valid && cmd_kind == K_INV_RNG &&
            cmd_first == $past(cmd_first) && cmd_last == $past(cmd_last));

    p_wt_no_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && wt_q |-> cmd_kind != K_CLEAN_RNG);

    p_rsvd_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> op_q != OP_RSVD);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && !req_ready);
endmodule

bind cmr_splitter cmr_splitter_chk #(
    .ADDR_W          (ADDR_W),
    .LINE_BYTES      (LINE_BYTES),
    .PAGE_BYTES      (PAGE_BYTES),
    .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .wt_override (wt_override),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_kind    (cmd_kind),
    .cmd_first   (cmd_first),
    .cmd_last    (cmd_last),
    .done        (done)
);

// File: tb/tb_cmr_splitter.sv
`timescale 1ns/1ps
module tb_cmr_splitter;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_limit = '0;
    logic [1:0]    req_op = 2'd0;
    logic          wt_override = 1'b0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_first;
    logic [AW-1:0] cmd_last;
    logic          done;

    int n_checks = 0;
    int n_fails  = 0;

    longint exp_k[$];
    longint exp_f[$];
    longint exp_l[$];

    always #2 clk = ~clk;

    cmr_splitter dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_limit(req_limit),
        .req_op(req_op), .wt_override(wt_override),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_first(cmd_first), .cmd_last(cmd_last),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void push(input longint k, input longint f, input longint l);
        exp_k.push_back(k);
        exp_f.push_back(f);
        exp_l.push_back(l);
    endfunction

    function automatic longint chunk_end(input longint s, input longint e);
        longint ce = e;
        if (ce > s + 1024) ce = s + 1024;
        if (ce > (s | 64'hFFF) + 1) ce = (s | 64'hFFF) + 1;
        return ce;
    endfunction

    function automatic void build_exp(input longint s, input longint e,
                                      input int op, input bit wt);
        longint ce;
        exp_k.delete(); exp_f.delete(); exp_l.delete();
        if (op == 0) begin
            if ((s & 31) != 0) begin
                push(2, s & ~64'd31, s & ~64'd31);
                s = (s | 31) + 1;
            end
            if (s < e && (e & 31) != 0) begin
                push(2, e & ~64'd31, e & ~64'd31);
                e = e & ~64'd31;
            end
            while (s < e) begin
                ce = chunk_end(s, e);
                push(1, s, ce - 32);
                s = ce;
            end
        end else if (op == 1 || op == 2) begin
            s = s & ~64'd31;
            e = (e + 31) & ~64'd31;
            if (!(op == 1 && wt)) begin
                while (s < e) begin
                    ce = chunk_end(s, e);
                    if (!wt) push(0, s, ce - 32);
                    if (op == 2) push(1, s, ce - 32);
                    s = ce;
                end
            end
        end
    endfunction

    function automatic string tag_of(input longint k, input int op, input bit wt);
        if (k == 2) return "R4/R5";
        if (op == 2 && !wt) return "R7";
        if (op == 2 || wt) return "R8";
        if (op == 1) return "R6";
        return "R3";
    endfunction

    task automatic run_req(input longint s, input longint e, input int op, input bit wt);
        int  got = 0;
        bit  seen_done = 0;
        bit  prev_hs;
        bit  stall = 0;
        bit  cr;
        logic [1:0]    sk;
        logic [AW-1:0] sf, sl;
        string t;
        build_exp(s, e, op, wt);
        @(negedge clk);
        chk(req_ready === 1'b1 && done === 1'b0, "R2", "idle before request",
            {req_ready, done}, 2'b10);
        req_base = s[AW-1:0]; req_limit = e[AW-1:0];
        req_op = op[1:0]; wt_override = wt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        prev_hs = 1'b1;
        for (int n = 0; n < 5000 && !seen_done; n++) begin
            if (done === 1'b1) begin
                seen_done = 1'b1;
                chk(prev_hs, "R9", "done one cycle after final handshake", 0, 1);
                chk(got == exp_k.size(), (op == 3) ? "R10" : "R9",
                    "command count at done", got, exp_k.size());
            end else begin
                if (n == 0)
                    chk(req_ready === 1'b0, "R2", "busy after accept", req_ready, 0);
                if (stall)
                    chk(cmd_valid && cmd_kind == sk && cmd_first == sf && cmd_last == sl,
                        "R2", "command held under stall", cmd_first, sf);
                cr = ($urandom % 4) != 0;
                cmd_ready = cr;
                prev_hs = cmd_valid && cr;
                if (cmd_valid && cr) begin
                    if (got < exp_k.size()) begin
                        t = tag_of(exp_k[got], op, wt);
                        chk(cmd_kind == exp_k[got], t, "kind", cmd_kind, exp_k[got]);
                        chk(cmd_first == exp_f[got][AW-1:0], t, "first", cmd_first, exp_f[got]);
                        chk(cmd_last == exp_l[got][AW-1:0], t, "last", cmd_last, exp_l[got]);
                    end else begin
                        chk(1'b0, (op == 3) ? "R10" : "R9", "unexpected command", cmd_first, 0);
                    end
                    got++;
                end
                stall = cmd_valid && !cr;
                sk = cmd_kind; sf = cmd_first; sl = cmd_last;
            end
            @(negedge clk);
        end
        cmd_ready = 1'b0;
        if (!seen_done) chk(1'b0, "R9", "no done", 0, 1);
        chk(done === 1'b0, "R9", "done lasts one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1",
            "state in reset", {req_ready, cmd_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && cmd_valid === 1'b0 && done === 1'b0, "R1",
            "state after reset", {req_ready, cmd_valid, done}, 3'b100);

        run_req(64'h1005, 64'h1013, 0, 0);   // R4: both ends in one line, no high edge
        run_req(64'h1010, 64'h1050, 0, 0);   // R4 R5: two edges then one line
        run_req(64'h2000, 64'h2000, 0, 0);   // R10: empty invalidate
        run_req(64'h2C00, 64'h3800, 1, 0);   // R3 R6: size cap meets page end
        run_req(64'h4010, 64'h4C01, 1, 0);   // R6: rounding both ends
        run_req(64'h0FF0, 64'h1011, 2, 0);   // R7: flush across page
        run_req(64'h0FF0, 64'h1011, 2, 1);   // R8: flush under override
        run_req(64'h5000, 64'h6000, 1, 1);   // R8: clean under override
        run_req(64'h5000, 64'h6000, 3, 0);   // R10: reserved op
        run_req(64'h7000, 64'h6000, 2, 0);   // R10: end below start
        run_req(64'h8000, 64'h9000, 0, 0);   // R3: aligned page-sized invalidate

        for (int i = 0; i < 300; i++) begin
            longint s = 64'h10000 + longint'($urandom % 32'h8000);
            longint len = longint'($urandom % 3200);
            longint e = ($urandom % 16 == 0) ? s - len : s + len;
            run_req(s, e, int'($urandom % 4), ($urandom % 3) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule